// File: doc/BRIEF.md
# Grouped External Interrupt Controller

The block collects 28 asynchronous external interrupt lines. Each line passes through a two-flop synchroniser and then an event detector. The detector works on the level or on the edges of the line, according to a programmable trigger type. Detected events are held in a pending register until they are acknowledged. A per-line mask decides which pending bits can raise an interrupt. The masked pending bits are then OR-reduced into four grouped interrupt outputs of unequal size, which feed an upstream interrupt controller.

Software reaches four 32-bit registers through a simple single-cycle register bus. Two configuration registers hold the trigger types, one register holds the mask and one holds the pending bits. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested by asserting `bus_sel` with `bus_wr` low, and the data appears on `bus_rdata` from the following clock edge.

Top module: `xint_group_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the trigger fields are all 000, the mask bits of lines 0..27 are all 1, the pending bits are 0 and `grp_irq_o` is 0. The synchroniser and edge-history flops reset to 1, so an input held at 1 through reset raises no event.
- R2: Trigger code 001 is high level. The pending bit is set on every clock while the synchronised line is 1, so a clear only takes hold once the line has returned to 0.
- R3: Trigger code 000 is low level. The pending bit is set on every clock while the synchronised line is 0.
- R4: Trigger codes 100 and 101 are rising edge. The pending bit is set by a 0 to 1 transition of the line, and a 1 to 0 transition leaves it unchanged.
- R5: Trigger codes 010 and 011 are falling edge. The pending bit is set by a 1 to 0 transition, and a 0 to 1 transition leaves it unchanged.
- R6: Trigger codes 110 and 111 are both edges. Either transition sets the pending bit.
- R7: Word address 0 configures lines 0..15 and word address 1 configures lines 16..27. Lines 2k and 2k+1 of a register share one 3-bit field at bits [4j+2:4j], where j is the pair's index within that register. Unused bits read as 0.
- R8: Writing to the pending register (word address 3) clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. A new event in the same cycle wins over the clear.
- R9: In the mask register (word address 2), a 1 blocks the line from the group outputs. A 0 lets it through. Reading the pending register returns the raw pending bits whatever the mask.
- R10: `grp_irq_o[0]` covers lines 0..3, `[1]` covers 4..11, `[2]` covers 12..19 and `[3]` covers 20..27. Each output is the OR of pending AND NOT mask over its lines.
- R11: Bits 31..28 of the mask and pending registers always read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 cfg low, 1 cfg high, 2 mask, 3 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ext_irq_i | input | 28 | Asynchronous external interrupt lines |
| grp_irq_o | output | 4 | Grouped interrupt outputs |

## Verification
The hardest situation to reach is an acknowledge that arrives while a level-triggered line is still active. The clear must lose to the re-set, and it must then succeed once the line has dropped. The stimulus holds a line high under a high-level trigger and writes the clear. It then reads the pending register back, releases the line, waits out the synchroniser and clears again. Pair sharing is exercised the same way: one line of a pair is reconfigured, and the event is then raised on its partner.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int NLINES       = 28;
  localparam int NGRP         = 4;
  localparam int REG_W        = 32;
  localparam int ADDR_W       = 2;
  localparam int TRIG_W       = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int NPAIRS        = (NLINES + 1) / 2;
  localparam int PAIRS_PER_REG = REG_W / FIELD_STRIDE;
  localparam int NCFG          = (NPAIRS + PAIRS_PER_REG - 1) / PAIRS_PER_REG;

  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_PEND = 2'd3;

  localparam int GRP_FIRST [NGRP] = '{0, 4, 12, 20};
  localparam int GRP_LAST  [NGRP] = '{3, 11, 19, 27};

  typedef enum logic [1:0] {
    TK_LEVEL = 2'b00,
    TK_FALL  = 2'b01,
    TK_RISE  = 2'b10,
    TK_BOTH  = 2'b11
  } trig_kind_e;
endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xint_line_sync.sv
module xint_line_sync #(
  parameter int          WIDTH = 28,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      stab_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic              evt_o
);
  logic       prev_q;
  logic       rise, fall;
  trig_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_i;
  end

  always_comb begin
    rise = line_i & ~prev_q;
    fall = ~line_i & prev_q;
    kind = trig_kind_e'(trig_i[2:1]);
    unique case (kind)
      TK_LEVEL: evt_o = trig_i[0] ? line_i : ~line_i;
      TK_FALL:  evt_o = fall;
      TK_RISE:  evt_o = rise;
      TK_BOTH:  evt_o = rise | fall;
      default:  evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xint_group_or.sv
module xint_group_or
  import xint_pkg::*;
#(
  parameter int FIRST = 0,
  parameter int LAST  = 3
) (
  input  logic [NLINES-1:0] active_i,
  output logic              irq_o
);
  assign irq_o = |active_i[LAST:FIRST];
endmodule

// File: rtl/xint_group_ctrl.sv
module xint_group_ctrl
  import xint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NLINES-1:0] ext_irq_i,
  output logic [NGRP-1:0]   grp_irq_o
);
  localparam int NPAD = NCFG * PAIRS_PER_REG;

  logic              rst_int_n;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] evt;
  logic [NLINES-1:0] mask_q, mask_nxt;
  logic [NLINES-1:0] pend_q, pend_nxt, pend_clr;
  logic [TRIG_W-1:0] cfg_q   [NPAIRS];
  logic [TRIG_W-1:0] cfg_nxt [NPAIRS];
  logic [TRIG_W-1:0] cfg_pad [NPAD];
  logic [NCFG-1:0]   cfg_we;
  logic              mask_we, pend_we, rd_en;
  logic [REG_W-1:0]  rdata_q, rdata_nxt;

  xint_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  xint_line_sync #(.WIDTH(NLINES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(ext_irq_i), .sync_o(line_s)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    xint_detect u_det (
      .clk(clk), .rst_n(rst_int_n), .line_i(line_s[n]),
      .trig_i(cfg_q[n/2]), .evt_o(evt[n])
    );
  end

  // bus decode
  always_comb begin
    for (int r = 0; r < NCFG; r++)
      cfg_we[r] = bus_sel && bus_wr && (bus_addr == ADDR_W'(r));
    mask_we = bus_sel && bus_wr && (bus_addr == A_MASK);
    pend_we = bus_sel && bus_wr && (bus_addr == A_PEND);
    rd_en   = bus_sel && !bus_wr;
  end

  // next-state
  always_comb begin
    for (int p = 0; p < NPAIRS; p++)
      cfg_nxt[p] = cfg_we[p / PAIRS_PER_REG]
                 ? bus_wdata[(p % PAIRS_PER_REG) * FIELD_STRIDE +: TRIG_W]
                 : cfg_q[p];
    mask_nxt = mask_we ? bus_wdata[NLINES-1:0] : mask_q;
    pend_clr = pend_we ? bus_wdata[NLINES-1:0] : '0;
    pend_nxt = (pend_q & ~pend_clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int p = 0; p < NPAIRS; p++) cfg_q[p] <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      for (int p = 0; p < NPAIRS; p++) cfg_q[p] <= cfg_nxt[p];
      mask_q <= mask_nxt;
      pend_q <= pend_nxt;
    end
  end

  // read path
  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    if (p < NPAIRS) begin : g_used
      assign cfg_pad[p] = cfg_q[p];
    end else begin : g_unused
      assign cfg_pad[p] = '0;
    end
  end

  always_comb begin
    rdata_nxt = '0;
    if (bus_addr == A_MASK) begin
      rdata_nxt[NLINES-1:0] = mask_q;
    end else if (bus_addr == A_PEND) begin
      rdata_nxt[NLINES-1:0] = pend_q;
    end else begin
      for (int r = 0; r < NCFG; r++)
        if (bus_addr == ADDR_W'(r))
          for (int k = 0; k < PAIRS_PER_REG; k++)
            rdata_nxt[k*FIELD_STRIDE +: TRIG_W] = cfg_pad[r*PAIRS_PER_REG + k];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

  // grouping
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    xint_group_or #(.FIRST(GRP_FIRST[g]), .LAST(GRP_LAST[g])) u_or (
      .active_i(pend_q & ~mask_q), .irq_o(grp_irq_o[g])
    );
  end
endmodule

// File: rtl/xint_checker.sv
module xint_checker
  import xint_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] evt,
  input logic [NGRP-1:0]   grp_irq_o
);
  p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && pend_q == '0));

  p_no_spurious_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_PEND)
      |=> ((pend_q & $past(bus_wdata[NLINES-1:0]) & ~$past(evt)) == '0));

  p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (grp_irq_o == '0));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && bus_addr >= A_MASK) |-> (bus_rdata[REG_W-1:NLINES] == '0));
endmodule

bind xint_group_ctrl xint_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mask_q(mask_q), .pend_q(pend_q), .evt(evt), .grp_irq_o(grp_irq_o)
);

// File: tb/sim_xint_group_ctrl.sv
module sim_xint_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] ext = '1;
  logic [3:0]  grp;
  logic        grp_req = 1'b0, take_rd = 1'b0, take_grp = 1'b0;
  int          checks = 0, errors = 0;
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [3:0]  gp_exp_q[$];
  string       gp_tag_q[$];

  always #4 clk = ~clk;

  xint_group_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq_i(ext), .grp_irq_o(grp)
  );

  // monitor
  always @(posedge clk) begin
    take_rd  <= bus_sel && !bus_wr;
    take_grp <= grp_req;
  end

  always @(negedge clk) begin
    if (take_rd && rd_exp_q.size() > 0) begin
      logic [31:0] e; string t;
      e = rd_exp_q.pop_front(); t = rd_tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
      end
    end
    if (take_grp && gp_exp_q.size() > 0) begin
      logic [3:0] e; string t;
      e = gp_exp_q.pop_front(); t = gp_tag_q.pop_front();
      checks++;
      if (grp !== e) begin
        errors++;
        $display("FAIL %s group actual=%b expected=%b", t, grp, e);
      end
    end
  end

  // driver
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    rd_exp_q.push_back(e); rd_tag_q.push_back(t);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic exp_grp(input logic [3:0] e, input string t);
    @(negedge clk); grp_req = 1;
    gp_exp_q.push_back(e); gp_tag_q.push_back(t);
    @(negedge clk); grp_req = 0;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); ext[n] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    line(n, 1'b1); line(n, 1'b0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grp !== 4'b0) begin
      errors++; $display("FAIL R1 grp in reset actual=%b expected=0000", grp);
    end
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 / R11 reset state
    exp_rd(2'd0, 32'h0, "R1 cfg0");
    exp_rd(2'd1, 32'h0, "R1 cfg1");
    exp_rd(2'd2, 32'h0FFF_FFFF, "R1 R11 mask");
    exp_rd(2'd3, 32'h0, "R1 pend");
    exp_grp(4'b0000, "R1 grp");
    // rising edge everywhere, then drop lines (falling ignored)
    wr(2'd0, 32'h4444_4444);
    wr(2'd1, 32'h0044_4444);
    @(negedge clk); ext = '0;
    repeat (6) @(negedge clk);
    exp_rd(2'd3, 32'h0, "R4 falling ignored");
    wr(2'd2, 32'h0);
    // R7 field layout, unused bits zero
    exp_rd(2'd1, 32'h0044_4444, "R7 cfg1");
    wr(2'd0, 32'hFFFF_FFFF);
    exp_rd(2'd0, 32'h7777_7777, "R7 unused bits");
    wr(2'd0, 32'h4444_4444);
    // R4 rising on line 5, group 1
    pulse(5);
    exp_rd(2'd3, 32'h0000_0020, "R4 rising line5");
    exp_grp(4'b0010, "R10 line5 group1");
    wr(2'd3, 32'h0);
    exp_rd(2'd3, 32'h0000_0020, "R8 write zero");
    wr(2'd3, 32'h0000_0020);
    exp_rd(2'd3, 32'h0, "R8 write one");
    // R2 high level on pair 6/7 (cfg0 field 3)
    wr(2'd0, 32'h4444_1444);
    line(7, 1'b1);
    exp_rd(2'd3, 32'h0000_0080, "R2 R7 line7 high");
    wr(2'd3, 32'h0000_0080);
    exp_rd(2'd3, 32'h0000_0080, "R2 clear while active");
    line(7, 1'b0);
    wr(2'd3, 32'h0000_0080);
    exp_rd(2'd3, 32'h0, "R2 clear after release");
    line(6, 1'b1);
    exp_rd(2'd3, 32'h0000_0040, "R7 partner line6 shares field");
    line(6, 1'b0);
    wr(2'd3, 32'h0000_0040);
    // R3 low level on pair 16/17 (cfg1 field 0)
    wr(2'd1, 32'h0044_4440);
    repeat (5) @(negedge clk);
    exp_rd(2'd3, 32'h0003_0000, "R3 low level 16/17");
    exp_grp(4'b0100, "R10 line16 group2");
    @(negedge clk); ext[16] = 1; ext[17] = 1;
    repeat (5) @(negedge clk);
    wr(2'd3, 32'h0003_0000);
    exp_rd(2'd3, 32'h0, "R3 inactive clears");
    // R5 falling on pair 26/27 (cfg1 field 5)
    wr(2'd1, 32'h0024_4440);
    line(27, 1'b1);
    exp_rd(2'd3, 32'h0, "R5 rising ignored");
    line(27, 1'b0);
    exp_rd(2'd3, 32'h0800_0000, "R5 falling line27");
    exp_grp(4'b1000, "R10 line27 group3");
    wr(2'd3, 32'h0800_0000);
    // R6 both edges on pair 0/1 (cfg0 field 0)
    wr(2'd0, 32'h4444_1446);
    line(0, 1'b1);
    exp_rd(2'd3, 32'h0000_0001, "R6 rise line0");
    exp_grp(4'b0001, "R10 line0 group0");
    wr(2'd3, 32'h1);
    line(0, 1'b0);
    exp_rd(2'd3, 32'h0000_0001, "R6 fall line0");
    wr(2'd3, 32'h1);
    // R9 mask line 12
    wr(2'd2, 32'h0000_1000);
    pulse(12);
    exp_rd(2'd3, 32'h0000_1000, "R9 raw pending under mask");
    exp_grp(4'b0000, "R9 masked line12");
    wr(2'd2, 32'h0);
    exp_grp(4'b0100, "R9 R10 unmask line12");
    wr(2'd3, 32'h0000_1000);
    // R10 group boundaries
    pulse(3);  exp_grp(4'b0001, "R10 line3 group0");  wr(2'd3, 32'h0000_0008);
    pulse(11); exp_grp(4'b0010, "R10 line11 group1"); wr(2'd3, 32'h0000_0800);
    pulse(19); exp_grp(4'b0100, "R10 line19 group2"); wr(2'd3, 32'h0008_0000);
    pulse(20); exp_grp(4'b1000, "R10 line20 group3"); wr(2'd3, 32'h0010_0000);
    exp_rd(2'd3, 32'h0, "R8 all cleared");
    // R11 upper bits
    wr(2'd2, 32'hFFFF_FFFF);
    exp_rd(2'd2, 32'h0FFF_FFFF, "R11 mask upper");
    wr(2'd3, 32'hF000_0000);
    exp_rd(2'd3, 32'h0, "R11 pend upper");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule